// File: doc/BRIEF.md
# Interrupt Request Arbiter

This block holds one pending flag per interrupt source and decides which pending request goes to the instruction sequencer. Peripherals set flags with single-cycle pulses, and software clears them with write pulses. Each flag is then qualified. A non-maskable source needs only its own enable bit. A maskable source also needs the global interrupt enable, and that enable must already have been open for one whole instruction. Among the qualified flags, the source with the highest index wins. The block shows the winner's binary index on `irq_vec` and raises `irq_req`.

The sequencer reports every instruction end on `instr_done`. A new request is latched only at such a boundary. The request is then held, with a frozen vector, until the sequencer returns a one-cycle `irq_ack`. On that acknowledge the block clears the flag of a single-source interrupt by itself. A flag that stands for several sources stays set, and the service routine must clear it.

Two state machines run in the block.

The arbitration machine has two states, `ARB_IDLE` and `ARB_REQ`:
- *latch*: `ARB_IDLE` goes to `ARB_REQ` when `instr_done` is high and at least one source qualifies.
- *accept*: `ARB_REQ` goes back to `ARB_IDLE` on `irq_ack`.

The global-enable gate has three states, `GATE_OFF`, `GATE_HOLD` and `GATE_OPEN`:
- *arm*: `GATE_OFF` goes to `GATE_HOLD` when `gie_in` is high.
- *count*: `GATE_HOLD` counts the `instr_done` pulses that arrive after the cycle in which the enable rose.
- *open*: `GATE_HOLD` goes to `GATE_OPEN` on the EI_DELAY-th counted boundary. That same boundary may already latch a maskable request.
- *drop*: any state goes to `GATE_OFF` when `gie_in` is low.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst_n` is low, and right after reset, all flags are 0 and `irq_req` is 0.
- R2: A 1 on `flag_set[i]` sets flag i, and a 1 on `flag_clr[i]` clears it. When both are 1 in the same cycle, the flag ends up set. `flag_q` shows the flags one cycle after the edge.
- R3: A maskable source i (bit i of NMI_MASK = 0, default sources 0 to 5) can be latched only when flag i, `src_en[i]` and the opened global gate are all 1.
- R4: A non-maskable source i (bit i of NMI_MASK = 1, default sources 6 and 7) can be latched whenever flag i and `src_en[i]` are 1, whatever the value of `gie_in`.
- R5: When several sources qualify, the highest index wins, and `irq_vec` carries that index in binary.
- R6: `irq_req` rises only in the cycle after an edge at which `instr_done` was 1. It then stays at 1, and `irq_vec` stays unchanged, until the edge at which `irq_ack` is 1.
- R7: On acknowledge, the flag of the latched source is cleared if that source is single-source (bit = 0 in MULTI_MASK), unless a set pulse for it arrives in the same cycle.
- R8: On acknowledge, the flag of a multi-source source (bit = 1 in MULTI_MASK, default sources 1 and 3) stays set.
- R9: After `gie_in` goes from 0 to 1, maskable sources stay blocked at the boundary in the rise cycle. They are first allowed at the EI_DELAY-th later boundary (default 1).
- R10: An `irq_ack` pulse while `irq_req` is 0 changes neither the flags nor the request state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_set | input | N_SRC | Peripheral set pulses, one per source |
| flag_clr | input | N_SRC | Software clear pulses, one per source |
| src_en | input | N_SRC | Individual enable bits |
| gie_in | input | 1 | Global interrupt enable level |
| instr_done | input | 1 | Instruction boundary pulse |
| irq_ack | input | 1 | Acceptance pulse from the sequencer |
| irq_req | output | 1 | Request to the sequencer |
| irq_vec | output | $clog2(N_SRC) | Binary index of the latched source |
| flag_q | output | N_SRC | Current pending flags |

## Verification
The bench lines up a set pulse and a clear pulse on the same bit in the same cycle. A design that lets the clear win would lose the interrupt. It raises the global enable in the same cycle as a boundary. A gate that opens too early would grant a maskable source one instruction too soon. It acknowledges a multi-source flag and checks that the flag is still set, which catches a design that wrongly clears shared flags. It also sends a stray acknowledge with no request outstanding, keeps a non-maskable source requesting while the global enable is 0, and runs random traffic. These checks would show a wrong priority order, a vector that changes while the request is held, or a flag that is lost.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic {
        ARB_IDLE,
        ARB_REQ
    } arb_state_t;

    typedef enum logic [1:0] {
        GATE_OFF,
        GATE_HOLD,
        GATE_OPEN
    } gate_state_t;
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    input  logic [N_SRC-1:0] ack_clr_i,
    output logic [N_SRC-1:0] flag_o
);
    logic [N_SRC-1:0] flag_n;

    // set dominates both software clear and acknowledge clear
    always_comb begin
        flag_n = (flag_o & ~(clr_i | ack_clr_i)) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_o <= '0;
        else        flag_o <= flag_n;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i))); // R2

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flag_o & $past(clr_i & ~set_i)) == '0)); // R2
endmodule

// File: rtl/irq_gie_gate.sv
module irq_gie_gate #(
    parameter int EI_DELAY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gie_i,
    input  logic done_i,
    output logic open_o
);
    import irq_pkg::*;

    localparam int CNT_W = (EI_DELAY > 1) ? $clog2(EI_DELAY + 1) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EI_DELAY - 1);

    gate_state_t      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             last_boundary;

    assign last_boundary = done_i && (cnt == LAST);

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (!gie_i) begin
            state_n = GATE_OFF;
            cnt_n   = '0;
        end else begin
            unique case (state)
                GATE_OFF: begin
                    state_n = GATE_HOLD;
                    cnt_n   = '0;
                end
                GATE_HOLD: begin
                    if (last_boundary)  state_n = GATE_OPEN;
                    else if (done_i)    cnt_n   = cnt + 1'b1;
                end
                GATE_OPEN: state_n = GATE_OPEN;
                default:   state_n = GATE_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GATE_OFF;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // output process: the closing boundary of the held instruction already counts
    always_comb begin
        unique case (state)
            GATE_OPEN: open_o = gie_i;
            GATE_HOLD: open_o = gie_i && last_boundary;
            default:   open_o = 1'b0;
        endcase
    end

    AST_GATE_SHUT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gie_i) |-> !open_o); // R9

    AST_GATE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        open_o |-> gie_i); // R3
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N_SRC = 8,
    parameter int VEC_W = 3
) (
    input  logic [N_SRC-1:0] elig_i,
    output logic             any_o,
    output logic [VEC_W-1:0] idx_o
);
    always_comb begin
        any_o = |elig_i;
        idx_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig_i[i]) idx_o = VEC_W'(i);
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int               N_SRC      = 8,
    parameter logic [N_SRC-1:0] NMI_MASK   = 8'hC0,
    parameter logic [N_SRC-1:0] MULTI_MASK = 8'h0A,
    parameter int               EI_DELAY   = 1,
    localparam int              VEC_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] flag_set,
    input  logic [N_SRC-1:0] flag_clr,
    input  logic [N_SRC-1:0] src_en,
    input  logic             gie_in,
    input  logic             instr_done,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic [N_SRC-1:0] flag_q
);
    import irq_pkg::*;

    arb_state_t       state, state_n;
    logic [VEC_W-1:0] vec_q, vec_n;
    logic             gie_open;
    logic [N_SRC-1:0] elig;
    logic             any_elig;
    logic [VEC_W-1:0] win_idx;
    logic             accept;
    logic [N_SRC-1:0] ack_clr;

    irq_gie_gate #(.EI_DELAY(EI_DELAY)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .gie_i  (gie_in),
        .done_i (instr_done),
        .open_o (gie_open)
    );

    assign elig = flag_q & src_en & (NMI_MASK | {N_SRC{gie_open}});

    irq_pick #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_pick (
        .elig_i (elig),
        .any_o  (any_elig),
        .idx_o  (win_idx)
    );

    assign accept = (state == ARB_REQ) && irq_ack;

    always_comb begin
        ack_clr = '0;
        if (accept && !MULTI_MASK[vec_q]) ack_clr[vec_q] = 1'b1;
    end

    irq_flags #(.N_SRC(N_SRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (flag_set),
        .clr_i     (flag_clr),
        .ack_clr_i (ack_clr),
        .flag_o    (flag_q)
    );

    always_comb begin
        state_n = state;
        vec_n   = vec_q;
        unique case (state)
            ARB_IDLE: begin
                if (instr_done && any_elig) begin
                    state_n = ARB_REQ;
                    vec_n   = win_idx;
                end
            end
            ARB_REQ: begin
                if (irq_ack) state_n = ARB_IDLE;
            end
            default: state_n = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ARB_IDLE;
            vec_q <= '0;
        end else begin
            state <= state_n;
            vec_q <= vec_n;
        end
    end

    // output process
    always_comb begin
        irq_req = (state == ARB_REQ);
        irq_vec = vec_q;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> irq_req); // R6

    AST_VEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> $stable(irq_vec)); // R6

    AST_REQ_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(instr_done)); // R6

    AST_MASKABLE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_req) && !NMI_MASK[irq_vec]) |-> $past(gie_in)); // R3

    AST_SINGLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && !MULTI_MASK[irq_vec] && !flag_set[irq_vec])
        |=> !flag_q[$past(irq_vec)]); // R7

    AST_MULTI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && MULTI_MASK[irq_vec] && flag_q[irq_vec] && !flag_clr[irq_vec])
        |=> flag_q[$past(irq_vec)]); // R8

    AST_IDLE_ACK_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && irq_ack && !instr_done) |=> !irq_req); // R10
endmodule

// File: tb/test_irq_arbiter.sv
`timescale 1ns/1ps
module test_irq_arbiter;
    localparam logic [7:0] NMI   = 8'hC0;
    localparam logic [7:0] MULTI = 8'h0A;
    localparam int         DELAY = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] flag_set = '0, flag_clr = '0, src_en = '0;
    logic       gie_in = 1'b0, instr_done = 1'b0, irq_ack = 1'b0;
    logic       irq_req;
    logic [2:0] irq_vec;
    logic [7:0] flag_q;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    logic [7:0] m_flag = '0;
    logic       m_req = 1'b0;
    logic [2:0] m_vec = '0;
    int         g_st = 0;
    int         g_cnt = 0;

    always #5 clk = ~clk;

    irq_arbiter i_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .flag_clr(flag_clr),
        .src_en(src_en), .gie_in(gie_in), .instr_done(instr_done), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vec(irq_vec), .flag_q(flag_q)
    );

    function automatic logic [2:0] top_idx(input logic [7:0] v);
        logic [2:0] r = '0;
        for (int i = 0; i < 8; i++) if (v[i]) r = 3'(i);
        return r;
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic [7:0] s, c, e, input logic g, d, a);
        logic       open;
        logic [7:0] elig, aclr;
        open = g && (g_st == 2 || (g_st == 1 && d && g_cnt == DELAY - 1));
        elig = m_flag & e & (NMI | {8{open}});
        aclr = '0;
        if (m_req && a && !MULTI[m_vec]) aclr[m_vec] = 1'b1;
        m_flag = (m_flag & ~(c | aclr)) | s;
        if (!m_req) begin
            if (d && elig != 0) begin
                m_req = 1'b1;
                m_vec = top_idx(elig);
            end
        end else if (a) m_req = 1'b0;
        if (!g) begin
            g_st = 0; g_cnt = 0;
        end else if (g_st == 0) begin
            g_st = 1; g_cnt = 0;
        end else if (g_st == 1 && d) begin
            if (g_cnt == DELAY - 1) g_st = 2;
            else g_cnt++;
        end
    endtask

    task automatic cyc(input logic [7:0] s, c, e, input logic g, d, a);
        flag_set = s; flag_clr = c; src_en = e; gie_in = g; instr_done = d; irq_ack = a;
        @(posedge clk);
        model_step(s, c, e, g, d, a);
        #1;
        chk(int'(flag_q), int'(m_flag), "R2 flags");
        chk(int'(irq_req), int'(m_req), "R6 request");
        if (m_req) chk(int'(irq_vec), int'(m_vec), "R5 vector");
    endtask

    initial begin
        #1_900_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk(int'(flag_q), 0, "R1 flags in reset");
        chk(int'(irq_req), 0, "R1 req in reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(int'(irq_req), 0, "R1 req after reset");

        // R2 set and clear together
        cyc(8'h02, 8'h02, 8'hFF, 0, 0, 0);
        chk(int'(flag_q), 8'h02, "R2 set beats clear");
        cyc(8'h00, 8'h02, 8'hFF, 0, 0, 0);
        chk(int'(flag_q), 8'h00, "R2 clear");

        // R10 ack without request; R4 non-maskable with gie low
        cyc(8'h40, 8'h00, 8'hFF, 0, 0, 0);
        cyc(8'h00, 8'h00, 8'hFF, 0, 0, 1);
        chk(int'(irq_req), 0, "R10 stray ack req");
        chk(int'(flag_q), 8'h40, "R10 stray ack flags");
        cyc(8'h00, 8'h00, 8'hFF, 0, 1, 0);
        chk(int'(irq_req), 1, "R4 nmi req with gie low");
        chk(int'(irq_vec), 6, "R4 nmi vector");
        cyc(8'h00, 8'h00, 8'hFF, 0, 1, 0);
        chk(int'(irq_req), 1, "R6 req held");
        chk(int'(irq_vec), 6, "R6 vec held");
        cyc(8'h00, 8'h00, 8'hFF, 0, 0, 1);
        chk(int'(irq_req), 0, "R7 req drops on ack");
        chk(int'(flag_q), 8'h00, "R7 single flag cleared");

        // R4 own enable still gates an nmi
        cyc(8'h80, 8'h00, 8'h7F, 0, 1, 0);
        cyc(8'h00, 8'h80, 8'h7F, 0, 1, 0);
        chk(int'(irq_req), 0, "R4 nmi disabled");

        // R3 maskable with gie low
        cyc(8'h04, 8'h00, 8'hFF, 0, 0, 0);
        cyc(8'h00, 8'h00, 8'hFF, 0, 1, 0);
        chk(int'(irq_req), 0, "R3 maskable gie low");

        // R9 enable rises on a boundary
        cyc(8'h00, 8'h00, 8'hFF, 1, 1, 0);
        chk(int'(irq_req), 0, "R9 blocked at enabling boundary");
        cyc(8'h00, 8'h00, 8'hFF, 1, 1, 0);
        chk(int'(irq_req), 1, "R9 granted after one instruction");
        chk(int'(irq_vec), 2, "R9 vector");
        cyc(8'h00, 8'h00, 8'hFF, 1, 0, 1);
        chk(int'(flag_q), 8'h00, "R7 flag 2 cleared");

        // R5 priority
        cyc(8'h26, 8'h00, 8'hFF, 1, 0, 0);
        cyc(8'h00, 8'h00, 8'hFF, 1, 1, 0);
        chk(int'(irq_vec), 5, "R5 highest index");
        cyc(8'h00, 8'h00, 8'hFF, 1, 0, 1);
        cyc(8'h00, 8'hFF, 8'hFF, 1, 0, 0);

        // R8 multi-source flag stays
        cyc(8'h08, 8'h00, 8'hFF, 1, 0, 0);
        cyc(8'h00, 8'h00, 8'hFF, 1, 1, 0);
        chk(int'(irq_vec), 3, "R8 vector");
        cyc(8'h00, 8'h00, 8'hFF, 1, 0, 1);
        chk(int'(flag_q[3]), 1, "R8 shared flag kept");
        cyc(8'h00, 8'h08, 8'hFF, 1, 0, 0);

        // R3 individual enable on a maskable source
        cyc(8'h04, 8'h00, 8'hFB, 1, 0, 0);
        cyc(8'h00, 8'h00, 8'hFB, 1, 1, 0);
        chk(int'(irq_req), 0, "R3 maskable disabled");
        cyc(8'h00, 8'h04, 8'hFF, 1, 0, 0);

        // random traffic against the reference
        begin
            logic g = 1'b1;
            for (int k = 0; k < 4000; k++) begin
                logic [7:0] s, c, e;
                logic d, a;
                s = 8'($urandom & $urandom & $urandom);
                c = 8'($urandom & $urandom & $urandom);
                e = ~8'($urandom & $urandom & $urandom);
                if (($urandom % 16) == 0) g = ~g;
                d = (($urandom % 3) == 0);
                a = m_req ? (($urandom % 2) == 0) : (($urandom % 8) == 0);
                cyc(s, c, e, g, d, a);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule